// File: doc/BRIEF.md
# MDIO Management Controller

This block is a host-programmed master for the two-wire PHY management bus. Software loads a clock divider and a preamble-suppress flag, a PHY address and a register address, and optionally 16 bits of write data. It then issues a command. The controller runs the MDC clock only while a frame is in flight and shifts one management frame out on MDIO. On a read it releases the line for the turnaround and data phases and shifts the PHY's reply in.

A scan command keeps the controller busy reading register 1 of the addressed PHY, one frame after another. After each scan frame it refreshes a link-fail flag from the returned status word. An invalid flag shows that scan is on but no scan frame has completed yet. Status is polled through the same register port. Software waits for busy to clear, takes the read data, and writes zero to the command register.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: The MDC half period in system clocks is D/2, where D is the written divider with bit 0 forced to zero, and raised to 2 if smaller. MDC stays low whenever no frame is in flight.
- R2: A write frame drives MDIO with the output enable high on every bit. The bits, sampled at each MDC rising edge, are: 32 ones (preamble), start 01, opcode 01, the 5-bit PHY address, the 5-bit register address, turnaround 10, then the 16 data bits MSB first. MDIO and its enable change only while MDC is low.
- R3: A read frame sends opcode 10. It drops the output enable for the last 18 bit periods (turnaround plus data). It samples MDIO on each of the 16 data-bit MDC rising edges, MSB first. The result is in the receive-data register once busy reads 0.
- R4: With mode bit 8 set, the frame omits the preamble and lasts exactly 32 MDC periods instead of 64.
- R5: Status bit 1 (busy) reads 1 from the cycle after a read or write command is written until the last MDC falling edge of the frame.
- R6: A command written while busy starts no frame. The running frame completes unchanged, and the receive-data register is not touched by the ignored command.
- R7: Command bit 0 (scan) starts back-to-back reads of PHY register 1. After each completes, status bit 0 (link fail) becomes the inverse of bit 2 of the returned word, and receive data takes that word. Clearing scan lets the current frame finish and starts no further frame.
- R8: Status bit 2 (invalid) sets when scan is switched on and clears when the first scan frame ends, or at once when scan is switched off.
- R9: After reset all six registers read 0, and MDC and the MDIO output enable are low.
- R10: The register indices are: 0 mode (divider in bits 7:0, preamble suppress in bit 8), 1 command (bit 0 scan, bit 1 read, bit 2 write), 2 address (PHY in bits 4:0, register in bits 12:8), 3 transmit data (bits 15:0), 4 receive data (read-only), 5 status (read-only). Mode bit 0 always reads 0.
- R11: If one command write sets both the read and write bits, a read frame is run.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr_en | input | 1 | Register write strobe |
| host_addr | input | 3 | Register index |
| host_wdata | input | 32 | Register write data |
| host_rdata | output | 32 | Read data of the indexed register, combinational |
| mdc_o | output | 1 | Management clock to the PHY |
| mdio_out_o | output | 1 | MDIO value driven when enabled |
| mdio_oe_o | output | 1 | MDIO output enable |
| mdio_in_i | input | 1 | MDIO value seen on the pad |

## Verification
The bench attacks the divider floor and odd divider values. A design that kept bit 0 or allowed a zero half period would give the wrong count of MDC high cycles per frame. Preamble suppression is checked by counting rising edges, which catches an off-by-one in the frame length. Read frames check where the output enable drops and that the reply comes back in MSB-first order, exposing a wrong turnaround position or a one-bit sampling slip. A second command issued mid-frame, a combined read-and-write command, and a scan that is switched off mid-flight probe the start arbitration. A faulty one would restart or corrupt a frame, or leave link-fail and invalid flags stale.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
   localparam int HOST_DW   = 32;
   localparam int REG_IDX_W = 3;

   typedef enum logic [REG_IDX_W-1:0] {
      RI_MODE = 3'd0,
      RI_CMD  = 3'd1,
      RI_ADDR = 3'd2,
      RI_TXD  = 3'd3,
      RI_RXD  = 3'd4,
      RI_STAT = 3'd5
   } reg_idx_e;

   localparam int CMD_SCAN  = 0;
   localparam int CMD_READ  = 1;
   localparam int CMD_WRITE = 2;

   localparam int ST_LINKFAIL = 0;
   localparam int ST_BUSY     = 1;
   localparam int ST_INVALID  = 2;

   localparam logic [1:0] FR_START = 2'b01;
   localparam logic [1:0] FR_OP_RD = 2'b10;
   localparam logic [1:0] FR_OP_WR = 2'b01;
   localparam logic [1:0] FR_TA_WR = 2'b10;
   localparam logic [1:0] FR_TA_RD = 2'b11;
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [DIV_W-2:0] half_raw,
   output logic             mdc,
   output logic             rise_stb,
   output logic             fall_stb
);
   localparam int HW = DIV_W - 1;

   logic [HW-1:0] half;
   logic [HW-1:0] cnt;
   logic          tick;

   // a divider below 2 is raised to 2, giving a half period of one clock
   assign half     = (half_raw == '0) ? HW'(1) : half_raw;
   assign tick     = en && (cnt == half - HW'(1));
   assign rise_stb = tick && !mdc;
   assign fall_stb = tick && mdc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         mdc <= 1'b0;
      end else if (!en) begin
         cnt <= '0;
         mdc <= 1'b0;
      end else if (tick) begin
         cnt <= '0;
         mdc <= !mdc;
      end else begin
         cnt <= cnt + HW'(1);
      end
   end
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
   import mdio_pkg::*;
#(
   parameter int PRE_LEN = 32,
   parameter int PHY_AW  = 5,
   parameter int REG_AW  = 5,
   parameter int DATA_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              op_read,
   input  logic              nopre,
   input  logic [PHY_AW-1:0] phy,
   input  logic [REG_AW-1:0] regad,
   input  logic [DATA_W-1:0] wdata,
   input  logic              rise_stb,
   input  logic              fall_stb,
   input  logic              mdio_in,
   output logic              busy,
   output logic              done,
   output logic              mdio_out,
   output logic              mdio_oe,
   output logic [DATA_W-1:0] rdata
);
   localparam int BODY_W  = 6 + PHY_AW + REG_AW + DATA_W;
   localparam int FRAME_W = PRE_LEN + BODY_W;
   localparam int CNT_W   = $clog2(FRAME_W + 1);
   localparam int TAIL_N  = 2 + DATA_W;

   logic [BODY_W-1:0]  body;
   logic [FRAME_W-1:0] load_sr;
   logic [CNT_W-1:0]   load_len;
   logic [FRAME_W-1:0] sr;
   logic [CNT_W-1:0]   left;
   logic               is_rd;
   logic [DATA_W-1:0]  rsh;
   logic               in_tail;
   logic               in_data;

   assign body = {FR_START,
                  op_read ? FR_OP_RD : FR_OP_WR,
                  phy, regad,
                  op_read ? FR_TA_RD : FR_TA_WR,
                  op_read ? {DATA_W{1'b1}} : wdata};

   generate
      if (PRE_LEN > 0) begin : g_pre
         // with suppression the body moves to the top and the ones trail unused
         assign load_sr  = nopre ? {body, {PRE_LEN{1'b1}}} : {{PRE_LEN{1'b1}}, body};
         assign load_len = nopre ? CNT_W'(BODY_W) : CNT_W'(FRAME_W);
      end else begin : g_nopre
         logic unused_nopre;
         assign unused_nopre = nopre;
         assign load_sr  = body;
         assign load_len = CNT_W'(BODY_W);
      end
   endgenerate

   assign in_tail  = left <= CNT_W'(TAIL_N);
   assign in_data  = left <= CNT_W'(DATA_W);
   assign done     = busy && fall_stb && (left == CNT_W'(1));
   assign mdio_out = busy && sr[FRAME_W-1];
   assign mdio_oe  = busy && !(is_rd && in_tail);
   assign rdata    = rsh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         sr    <= '0;
         left  <= '0;
         is_rd <= 1'b0;
      end else if (!busy) begin
         if (start) begin
            busy  <= 1'b1;
            sr    <= load_sr;
            left  <= load_len;
            is_rd <= op_read;
         end
      end else if (fall_stb) begin
         sr   <= {sr[FRAME_W-2:0], 1'b0};
         left <= left - CNT_W'(1);
         if (left == CNT_W'(1)) busy <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rsh <= '0;
      else if (busy && is_rd && rise_stb && in_data) rsh <= {rsh[DATA_W-2:0], mdio_in};
   end
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
   import mdio_pkg::*;
#(
   parameter int DIV_W    = 8,
   parameter int PRE_LEN  = 32,
   parameter int PHY_AW   = 5,
   parameter int REG_AW   = 5,
   parameter int DATA_W   = 16,
   parameter int SCAN_REG = 1,
   parameter int LINK_BIT = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 host_wr_en,
   input  logic [REG_IDX_W-1:0] host_addr,
   input  logic [HOST_DW-1:0]   host_wdata,
   output logic [HOST_DW-1:0]   host_rdata,
   output logic                 mdc_o,
   output logic                 mdio_out_o,
   output logic                 mdio_oe_o,
   input  logic                 mdio_in_i
);
   localparam int NOPRE_BIT = DIV_W;
   localparam int REG_LSB   = 8;

   generate
      if (DIV_W < 2 || DIV_W > 8) begin : g_bad_div
         $error("DIV_W must lie in 2..8");
      end
      if (PHY_AW > REG_LSB || REG_AW > 8 || DATA_W > HOST_DW || DATA_W < 2) begin : g_bad_field
         $error("address or data field does not fit the register layout");
      end
      if (LINK_BIT >= DATA_W || SCAN_REG >= (1 << REG_AW)) begin : g_bad_scan
         $error("scan register or link bit out of range");
      end
   endgenerate

   logic [DIV_W-2:0]  half_q;
   logic              nopre_q;
   logic [2:0]        cmd_q;
   logic [PHY_AW-1:0] phy_q;
   logic [REG_AW-1:0] reg_q;
   logic [DATA_W-1:0] txd_q;
   logic [DATA_W-1:0] rxd_q;
   logic              link_fail;
   logic              scan_inv;
   logic              cur_rd;
   logic              cur_scan;

   logic              wr_cmd, scan_en, scan_next, os_req, os_start, scan_start;
   logic              eng_start, eng_op_rd, eng_busy, eng_done;
   logic [REG_AW-1:0] eng_reg;
   logic [DATA_W-1:0] eng_rdata;
   logic              rise_stb, fall_stb;
   logic              unused_wd;

   assign unused_wd = ^host_wdata;

   assign wr_cmd     = host_wr_en && (host_addr == RI_CMD);
   assign scan_en    = cmd_q[CMD_SCAN];
   assign scan_next  = wr_cmd ? host_wdata[CMD_SCAN] : scan_en;
   assign os_req     = wr_cmd && (host_wdata[CMD_READ] || host_wdata[CMD_WRITE]);
   assign os_start   = os_req && !eng_busy;
   assign scan_start = scan_next && !eng_busy && !os_req;
   assign eng_start  = os_start || scan_start;
   // read wins over write when a single command asks for both
   assign eng_op_rd  = os_start ? host_wdata[CMD_READ] : 1'b1;
   assign eng_reg    = os_start ? reg_q : REG_AW'(SCAN_REG);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         half_q  <= '0;
         nopre_q <= 1'b0;
         phy_q   <= '0;
         reg_q   <= '0;
         txd_q   <= '0;
      end else if (host_wr_en) begin
         case (host_addr)
            RI_MODE: begin
               half_q  <= host_wdata[DIV_W-1:1];
               nopre_q <= host_wdata[NOPRE_BIT];
            end
            RI_ADDR: begin
               phy_q <= host_wdata[PHY_AW-1:0];
               reg_q <= host_wdata[REG_LSB +: REG_AW];
            end
            RI_TXD:  txd_q <= host_wdata[DATA_W-1:0];
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q     <= '0;
         rxd_q     <= '0;
         link_fail <= 1'b0;
         scan_inv  <= 1'b0;
         cur_rd    <= 1'b0;
         cur_scan  <= 1'b0;
      end else begin
         if (eng_start) begin
            cur_rd   <= eng_op_rd;
            cur_scan <= scan_start;
         end
         if (eng_done && cur_rd) rxd_q <= eng_rdata;
         if (eng_done && cur_scan) begin
            link_fail <= !eng_rdata[LINK_BIT];
            scan_inv  <= 1'b0;
         end
         if (wr_cmd) begin
            cmd_q <= host_wdata[2:0];
            if (host_wdata[CMD_SCAN] && !scan_en) scan_inv <= 1'b1;
            else if (!host_wdata[CMD_SCAN])       scan_inv <= 1'b0;
         end
      end
   end

   always_comb begin
      host_rdata = '0;
      case (host_addr)
         RI_MODE: begin
            host_rdata[DIV_W-1:1]  = half_q;
            host_rdata[NOPRE_BIT]  = nopre_q;
         end
         RI_CMD:  host_rdata[2:0] = cmd_q;
         RI_ADDR: begin
            host_rdata[PHY_AW-1:0]       = phy_q;
            host_rdata[REG_LSB +: REG_AW] = reg_q;
         end
         RI_TXD:  host_rdata[DATA_W-1:0] = txd_q;
         RI_RXD:  host_rdata[DATA_W-1:0] = rxd_q;
         RI_STAT: begin
            host_rdata[ST_LINKFAIL] = link_fail;
            host_rdata[ST_BUSY]     = eng_busy;
            host_rdata[ST_INVALID]  = scan_inv;
         end
         default: ;
      endcase
   end

   mdio_clk_div #(.DIV_W(DIV_W)) clk_div_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (eng_busy),
      .half_raw (half_q),
      .mdc      (mdc_o),
      .rise_stb (rise_stb),
      .fall_stb (fall_stb)
   );

   mdio_frame_eng #(
      .PRE_LEN (PRE_LEN),
      .PHY_AW  (PHY_AW),
      .REG_AW  (REG_AW),
      .DATA_W  (DATA_W)
   ) frame_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (eng_start),
      .op_read  (eng_op_rd),
      .nopre    (nopre_q),
      .phy      (phy_q),
      .regad    (eng_reg),
      .wdata    (txd_q),
      .rise_stb (rise_stb),
      .fall_stb (fall_stb),
      .mdio_in  (mdio_in_i),
      .busy     (eng_busy),
      .done     (eng_done),
      .mdio_out (mdio_out_o),
      .mdio_oe  (mdio_oe_o),
      .rdata    (eng_rdata)
   );
endmodule

// File: rtl/mdio_mgmt_ctrl_chk.sv
module mdio_mgmt_ctrl_chk (
   input logic clk,
   input logic rst_n,
   input logic eng_busy,
   input logic eng_done,
   input logic mdc_o,
   input logic mdio_out_o,
   input logic mdio_oe_o,
   input logic cur_rd,
   input logic cur_scan,
   input logic scan_en,
   input logic scan_inv,
   input logic link_fail
);
   AST_IDLE_PINS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !eng_busy |-> (!mdc_o && !mdio_oe_o)); // R1

   AST_LINE_STABLE_MDC_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (mdc_o && $past(mdc_o)) |-> ($stable(mdio_out_o) && $stable(mdio_oe_o))); // R2

   AST_RELEASE_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_busy && $fell(mdio_oe_o)) |-> cur_rd); // R3

   AST_DONE_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      eng_done |=> !eng_busy); // R5

   AST_FRAME_KIND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_busy && $past(eng_busy)) |-> ($stable(cur_rd) && $stable(cur_scan))); // R6

   AST_LINK_ONLY_ON_SCAN_END: assert property (@(posedge clk) disable iff (!rst_n)
      !(eng_done && cur_scan) |=> $stable(link_fail)); // R7

   AST_INVALID_NEEDS_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
      scan_inv |-> scan_en); // R8
endmodule

bind mdio_mgmt_ctrl mdio_mgmt_ctrl_chk chk_i (.*);

// File: tb/mdio_mgmt_ctrl_tb_top.sv
module mdio_mgmt_ctrl_tb_top;
   import mdio_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_wr_en = 1'b0;
   logic [2:0]  host_addr = 3'd0;
   logic [31:0] host_wdata = 32'd0;
   logic [31:0] host_rdata;
   logic        mdc_o, mdio_out_o, mdio_oe_o;
   logic        mdio_in_i;

   always #2 clk = ~clk;

   mdio_mgmt_ctrl dut_i (
      .clk(clk), .rst_n(rst_n),
      .host_wr_en(host_wr_en), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata),
      .mdc_o(mdc_o), .mdio_out_o(mdio_out_o), .mdio_oe_o(mdio_oe_o),
      .mdio_in_i(mdio_in_i)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   // PHY-side monitor and responder
   int rise_cnt = 0, fall_cnt = 0, hi_cnt = 0;
   int rise_base = 0, fall_base = 0, hi_base = 0;
   int flen = 64, pre = 32;
   logic [15:0] reply = 16'h0;
   logic cap [256];
   logic oecap [256];

   always @(posedge mdc_o) begin
      cap[rise_cnt % 256]   = mdio_out_o;
      oecap[rise_cnt % 256] = mdio_oe_o;
      rise_cnt++;
   end
   always @(negedge mdc_o) fall_cnt++;
   always @(negedge clk) if (mdc_o) hi_cnt++;

   always_comb begin
      int k;
      k = (fall_cnt - fall_base) % flen;
      if (k >= pre + 16 && k < pre + 32) mdio_in_i = reply[15 - (k - pre - 16)];
      else if (k == pre + 15)            mdio_in_i = 1'b0;
      else                               mdio_in_i = 1'b1;
   end

   // vector: [35] read, [34] no preamble, [33:26] divider, [25:21] phy, [20:16] reg, [15:0] data
   localparam int NVEC = 5;
   localparam logic [35:0] VEC [NVEC] = '{
      {1'b0, 1'b0, 8'd4, 5'h03, 5'h04, 16'hA5C3},
      {1'b1, 1'b0, 8'd7, 5'h11, 5'h1E, 16'h3C96},
      {1'b0, 1'b1, 8'd1, 5'h1F, 5'h00, 16'h8001},
      {1'b1, 1'b1, 8'd0, 5'h00, 5'h1F, 16'hFFFE},
      {1'b1, 1'b0, 8'd2, 5'h0A, 5'h05, 16'h0001}
   };

   function automatic int half_of(input logic [7:0] d);
      int h;
      h = int'(d[7:1]);
      if (h == 0) h = 1;
      return h;
   endfunction

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      host_addr = a; host_wdata = d; host_wr_en = 1'b1;
      @(negedge clk);
      host_wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      host_addr = a;
      #1;
      d = host_rdata;
   endtask

   task automatic wait_idle(input string req);
      logic [31:0] s;
      bit idle;
      idle = 1'b0;
      for (int i = 0; i < 4000; i++) begin
         @(negedge clk);
         rd(RI_STAT, s);
         if (!s[1]) begin idle = 1'b1; break; end
      end
      check({req, " busy clears"}, {31'd0, idle}, 32'd1);
   endtask

   task automatic mark();
      rise_base = rise_cnt; fall_base = fall_cnt; hi_base = hi_cnt;
   endtask

   task automatic frame_head(input int off, output logic [13:0] h);
      for (int i = 0; i < 14; i++) h = {h[12:0], cap[(rise_base + off + i) % 256]};
   endtask

   initial begin
      logic [35:0] t;
      logic [31:0] r, body_got;
      logic [13:0] head;
      logic rdf, npf;
      logic [7:0] dv;
      logic [4:0] ph, rg;
      logic [15:0] dt;
      int pre_ok, oe_ones, hexp, rb;

      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R9: reset state
      for (int a = 0; a < 6; a++) begin
         rd(3'(a), r);
         check("R9 register after reset", r, 32'd0);
      end
      check("R9 mdc low", {31'd0, mdc_o}, 32'd0);
      check("R9 oe low", {31'd0, mdio_oe_o}, 32'd0);

      // R10: field positions and divider bit 0
      wr(RI_MODE, 32'h0000_01FF);
      rd(RI_MODE, r); check("R10 mode readback", r, 32'h0000_01FE);
      wr(RI_ADDR, 32'hFFFF_FFFF);
      rd(RI_ADDR, r); check("R10 address readback", r, 32'h0000_1F1F);
      wr(RI_TXD, 32'hFFFF_1234);
      rd(RI_TXD, r); check("R10 txdata readback", r, 32'h0000_1234);
      wr(RI_RXD, 32'h0000_5555);
      rd(RI_RXD, r); check("R10 rxdata read-only", r, 32'd0);

      // table of frames
      for (int v = 0; v < NVEC; v++) begin
         t = VEC[v];
         rdf = t[35]; npf = t[34]; dv = t[33:26]; ph = t[25:21]; rg = t[20:16]; dt = t[15:0];
         wr(RI_MODE, {23'd0, npf, dv});
         wr(RI_ADDR, {19'd0, rg, 3'd0, ph});
         wr(RI_TXD, {16'd0, dt});
         reply = dt; flen = npf ? 32 : 64; pre = npf ? 0 : 32; hexp = half_of(dv);
         mark();
         wr(RI_CMD, rdf ? 32'd2 : 32'd4);
         rd(RI_STAT, r); check("R5 busy after command", {31'd0, r[1]}, 32'd1);
         wait_idle("R5");
         wr(RI_CMD, 32'd0);
         pre_ok = 0; oe_ones = 0; body_got = '0;
         for (int i = 0; i < flen; i++) begin
            if (i < pre) begin
               if (cap[(rise_base + i) % 256] === 1'b1 && oecap[(rise_base + i) % 256] === 1'b1) pre_ok++;
            end else begin
               body_got = {body_got[30:0], cap[(rise_base + i) % 256]};
            end
            if (oecap[(rise_base + i) % 256] === 1'b1) oe_ones++;
         end
         check("R4 MDC periods per frame", 32'(rise_cnt - rise_base), 32'(flen));
         check("R1 MDC high cycles", 32'(hi_cnt - hi_base), 32'(flen * hexp));
         check("R2 preamble ones", 32'(pre_ok), 32'(pre));
         if (!rdf) begin
            check("R2 write frame body", body_got, {FR_START, FR_OP_WR, ph, rg, FR_TA_WR, dt});
            check("R2 oe held for write", 32'(oe_ones), 32'(flen));
         end else begin
            check("R3 read frame head", {18'd0, body_got[31:18]}, {18'd0, FR_START, FR_OP_RD, ph, rg});
            check("R3 oe released tail", 32'(oe_ones), 32'(flen - 18));
            rd(RI_RXD, r); check("R3 read data", r, {16'd0, dt});
         end
      end

      // R6: command during busy is ignored
      wr(RI_MODE, 32'd2);
      wr(RI_ADDR, 32'h0000_0302);
      wr(RI_TXD, 32'h0000_1234);
      reply = 16'hBEEF; flen = 64; pre = 32;
      mark();
      wr(RI_CMD, 32'd4);
      repeat (5) @(negedge clk);
      wr(RI_CMD, 32'd2);
      wait_idle("R6");
      repeat (40) @(negedge clk);
      wr(RI_CMD, 32'd0);
      check("R6 only one frame", 32'(rise_cnt - rise_base), 32'd64);
      frame_head(32, head);
      check("R6 frame stays write", {18'd0, head}, {18'd0, FR_START, FR_OP_WR, 5'h02, 5'h03});
      rd(RI_RXD, r); check("R6 rxdata untouched", r, 32'h0000_0001);

      // R11: read beats write
      reply = 16'h5A5A;
      mark();
      wr(RI_CMD, 32'd6);
      wait_idle("R11");
      wr(RI_CMD, 32'd0);
      frame_head(32, head);
      check("R11 read opcode wins", {30'd0, head[11:10]}, {30'd0, FR_OP_RD});
      rd(RI_RXD, r); check("R11 read data", r, 32'h0000_5A5A);

      // R7 / R8: scan
      wr(RI_ADDR, 32'h0000_1F05);
      reply = 16'h0000;
      mark();
      wr(RI_CMD, 32'd1);
      rd(RI_STAT, r); check("R8 invalid on scan start", {29'd0, r[2:0]}, 32'h6);
      repeat (140) @(negedge clk);
      rd(RI_STAT, r); check("R7 link fail set, R8 invalid cleared", {29'd0, r[2:0]}, 32'h3);
      frame_head(32, head);
      check("R7 scan reads register 1", {18'd0, head}, {18'd0, FR_START, FR_OP_RD, 5'h05, 5'h01});
      rd(RI_RXD, r); check("R7 scan data", r, 32'd0);
      reply = 16'h0004;
      repeat (300) @(negedge clk);
      rd(RI_STAT, r); check("R7 link fail cleared", {31'd0, r[0]}, 32'd0);
      rd(RI_RXD, r); check("R7 scan data refreshed", r, 32'h0000_0004);
      wr(RI_CMD, 32'd0);
      rd(RI_STAT, r); check("R8 invalid off with scan", {31'd0, r[2]}, 32'd0);
      wait_idle("R7");
      rb = rise_cnt;
      repeat (60) @(negedge clk);
      check("R7 no frame after scan off", 32'(rise_cnt - rb), 32'd0);
      check("R1 mdc low when idle", {31'd0, mdc_o}, 32'd0);
      check("R1 oe low when idle", {31'd0, mdio_oe_o}, 32'd0);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule